// File: doc/BRIEF.md
# Left-Hand Wall-Following Step Controller

This block steers a robot through a grid maze by the left-hand rule. Each navigation step starts with a turn to the left. The controller then asks for one sensor sample that describes the cell now directly in front of the robot. From that sample it chooses the next action. A free cell leads to a forward move, after which the next step begins with another left turn. A door leads to the interact action, which ends the run. Anything else leads to a right turn, and the controller asks for a fresh sample without turning left first.

Actions leave on a valid/ready channel. Sensor samples arrive on a second valid/ready channel, which the controller opens only after a turn has been accepted. At most one of the two channels is active in any cycle. The maze, the robot's pose and any display are outside the block. Only the decision sequence lives here.

Top module: `maze_lhr_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the controller offers a turn-left action (`act_vld`=1, `act_code`=0), `done` is 0 and `sns_rdy` is 0.
- R2: Action codes on `act_code` are: turn left = 0, move forward = 1, turn right = 2, interact = 4.
- R3: Once a turn action (left or right) is accepted, the next cycle has `sns_rdy`=1 and `act_vld`=0 until a sensor sample is taken.
- R4: A sample code 0 (free cell) taken while `sns_rdy`=1 makes the next action a move forward. Once that move is accepted, the next action is turn left.
- R5: A sample code 3 (door) makes the next action interact. Once that action is accepted, `done` rises.
- R6: A sample of code 1 (wall), or of any other code that is neither 0 nor 3 (for example 2), makes the next action a turn right. That turn is followed directly by a new sample request, with no turn left in between.
- R7: While `act_vld`=1 and `act_rdy`=0, `act_code` and `act_vld` hold their values, and `sns_vld` has no effect.
- R8: `act_vld` and `sns_rdy` are never high in the same cycle.
- R9: A reset in the middle of a run returns the controller to offering turn left.
- R10: `done` stays high until reset. While it is high, no action is offered and no sample is requested.

Parameters: `SNS_W` sets the width of the sensor code. It must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| act_vld | output | 1 | An action is offered |
| act_rdy | input | 1 | The robot accepts the offered action |
| act_code | output | 3 | Action code (0 left, 1 move, 2 right, 4 interact) |
| sns_rdy | output | 1 | The controller requests a sample of the cell ahead |
| sns_vld | input | 1 | A sensor sample is present |
| sns_code | input | SNS_W | Cell ahead (0 free, 1 wall, 3 door, others treated as wall) |
| done | output | 1 | Sticky: the door has been used |

## Verification
Two grid mazes are walked by a model of the robot in the bench, and the action sequence is compared with a left-hand-rule reference built from the same grid.

- The first maze has a cell of code 2 next to the start. This separates correct handling of an unlisted code, which must act as a wall, from handling it as a free cell or a door.
- The second maze starts in a dead end. It needs three right turns in a row, which shows that a right turn leads straight back to a sample and never to a left turn.
- Stalled acceptance, with a door code waved on the sensor input during the stall, must not move the offered action.
- A reset after a right turn, and a reset after `done`, must both bring back the turn-left offer.

// File: rtl/maze_lhr_pkg.sv
package maze_lhr_pkg;
  localparam int ACT_W = 3;

  localparam logic [ACT_W-1:0] ACT_LEFT  = 3'd0;
  localparam logic [ACT_W-1:0] ACT_MOVE  = 3'd1;
  localparam logic [ACT_W-1:0] ACT_RIGHT = 3'd2;
  localparam logic [ACT_W-1:0] ACT_USE   = 3'd4;

  typedef enum logic [2:0] {
    ST_LEFT, ST_PROBE, ST_MOVE, ST_RIGHT, ST_DOOR, ST_DONE
  } step_e;

  typedef enum logic [1:0] {CL_OPEN, CL_BLOCK, CL_EXIT} cell_e;

  function automatic logic [ACT_W-1:0] action_of(input step_e s);
    case (s)
      ST_MOVE:  action_of = ACT_MOVE;
      ST_RIGHT: action_of = ACT_RIGHT;
      ST_DOOR:  action_of = ACT_USE;
      default:  action_of = ACT_LEFT;
    endcase
  endfunction

  function automatic logic offers_action(input step_e s);
    offers_action = (s == ST_LEFT) || (s == ST_MOVE) ||
                    (s == ST_RIGHT) || (s == ST_DOOR);
  endfunction
endpackage

// File: rtl/maze_lhr_sense.sv
module maze_lhr_sense
  import maze_lhr_pkg::*;
#(
  parameter int SNS_W = 2
) (
  input  logic [SNS_W-1:0] code,
  output cell_e            cls
);
  localparam logic [SNS_W-1:0] CODE_FREE = SNS_W'(0);
  localparam logic [SNS_W-1:0] CODE_DOOR = SNS_W'(3);

  always_comb begin
    if (code == CODE_FREE)      cls = CL_OPEN;
    else if (code == CODE_DOOR) cls = CL_EXIT;
    else                        cls = CL_BLOCK;
  end
endmodule

// File: rtl/maze_lhr_fsm.sv
module maze_lhr_fsm
  import maze_lhr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  act_fire,
  input  logic  sns_fire,
  input  cell_e cls,
  output step_e st
);
  step_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_LEFT:  if (act_fire) st_nx = ST_PROBE;
      ST_PROBE: if (sns_fire) begin
        case (cls)
          CL_OPEN: st_nx = ST_MOVE;
          CL_EXIT: st_nx = ST_DOOR;
          default: st_nx = ST_RIGHT;
        endcase
      end
      ST_MOVE:  if (act_fire) st_nx = ST_LEFT;
      ST_RIGHT: if (act_fire) st_nx = ST_PROBE;
      ST_DOOR:  if (act_fire) st_nx = ST_DONE;
      default:  st_nx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_LEFT;
    else     st <= st_nx;
  end

  // R10: the finished state is never left without reset
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |=> (st == ST_DONE));

  // R6: a right turn never returns to a left turn directly
  a_r6_right_to_probe: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RIGHT && act_fire) |=> (st == ST_PROBE));
endmodule

// File: rtl/maze_lhr_emit.sv
module maze_lhr_emit
  import maze_lhr_pkg::*;
(
  input  step_e            st,
  output logic             act_vld,
  output logic [ACT_W-1:0] act_code,
  output logic             sns_rdy,
  output logic             done
);
  always_comb begin
    act_vld  = offers_action(st);
    act_code = action_of(st);
    sns_rdy  = (st == ST_PROBE);
    done     = (st == ST_DONE);
  end
endmodule

// File: rtl/maze_lhr_ctrl.sv
module maze_lhr_ctrl
  import maze_lhr_pkg::*;
#(
  parameter int SNS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             act_vld,
  input  logic             act_rdy,
  output logic [2:0]       act_code,
  output logic             sns_rdy,
  input  logic             sns_vld,
  input  logic [SNS_W-1:0] sns_code,
  output logic             done
);
  cell_e cls;
  step_e st;
  logic  act_fire;
  logic  sns_fire;
  logic  code_blocked;

  assign act_fire     = act_vld && act_rdy;
  assign sns_fire     = sns_rdy && sns_vld;
  assign code_blocked = (sns_code != SNS_W'(0)) && (sns_code != SNS_W'(3));

  maze_lhr_sense #(.SNS_W(SNS_W)) u_sense (.code(sns_code), .cls(cls));

  maze_lhr_fsm u_fsm (
    .clk(clk), .rst(rst), .act_fire(act_fire), .sns_fire(sns_fire),
    .cls(cls), .st(st)
  );

  maze_lhr_emit u_emit (
    .st(st), .act_vld(act_vld), .act_code(act_code),
    .sns_rdy(sns_rdy), .done(done)
  );

  a_r1_reset_offer: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (act_vld && act_code == ACT_LEFT && !done && !sns_rdy));

  a_r3_turn_then_probe: assert property (@(posedge clk) disable iff (rst)
    (act_fire && (act_code == ACT_LEFT || act_code == ACT_RIGHT))
      |=> (sns_rdy && !act_vld));

  a_r4_free_moves: assert property (@(posedge clk) disable iff (rst)
    (sns_fire && sns_code == SNS_W'(0)) |=> (act_vld && act_code == ACT_MOVE));

  a_r4_move_then_left: assert property (@(posedge clk) disable iff (rst)
    (act_fire && act_code == ACT_MOVE) |=> (act_vld && act_code == ACT_LEFT));

  a_r5_door_uses: assert property (@(posedge clk) disable iff (rst)
    (sns_fire && sns_code == SNS_W'(3)) |=> (act_vld && act_code == ACT_USE));

  a_r5_use_ends: assert property (@(posedge clk) disable iff (rst)
    (act_fire && act_code == ACT_USE) |=> done);

  a_r6_block_turns_right: assert property (@(posedge clk) disable iff (rst)
    (sns_fire && code_blocked) |=> (act_vld && act_code == ACT_RIGHT));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (act_vld && !act_rdy) |=> (act_vld && $stable(act_code)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(act_vld && sns_rdy));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!act_vld && !sns_rdy));
endmodule

// File: tb/sim_maze_lhr_ctrl.sv
module sim_maze_lhr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       act_vld;
  logic       act_rdy = 1'b0;
  logic [2:0] act_code;
  logic       sns_rdy;
  logic       sns_vld = 1'b0;
  logic [1:0] sns_code = 2'd0;
  logic       done;

  int checks = 0;
  int failures = 0;

  byte grid [0:7][0:7];
  int  exp_act [0:255];
  int  exp_n;

  always #10 clk = ~clk;

  maze_lhr_ctrl #(.SNS_W(2)) u0 (
    .clk(clk), .rst(rst), .act_vld(act_vld), .act_rdy(act_rdy),
    .act_code(act_code), .sns_rdy(sns_rdy), .sns_vld(sns_vld),
    .sns_code(sns_code), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cell_at(input int x, input int y);
    if (x < 0 || y < 0 || x > 7 || y > 7) return 1;
    case (grid[y][x])
      8'h2E:   return 0; // '.'
      8'h44:   return 3; // 'D'
      8'h78:   return 2; // 'x'
      default: return 1;
    endcase
  endfunction

  function automatic int step_x(input int d);
    return (d == 1) ? 1 : (d == 3) ? -1 : 0;
  endfunction

  function automatic int step_y(input int d);
    return (d == 2) ? 1 : (d == 0) ? -1 : 0;
  endfunction

  task automatic load_maze(input string r0, input string r1, input string r2, input string r3);
    string rows [4];
    rows = '{r0, r1, r2, r3};
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++)
        grid[y][x] = (y < 4 && x < rows[y].len()) ? rows[y][x] : 8'h23;
  endtask

  // Reference left-hand walk: directions 0 N, 1 E, 2 S, 3 W
  task automatic build_ref(input int sx, input int sy, input int sd);
    int x = sx;
    int y = sy;
    int d = sd;
    bit fin = 0;
    exp_n = 0;
    while (!fin && exp_n < 250) begin
      exp_act[exp_n++] = 0;
      d = (d + 3) % 4;
      forever begin
        int c = cell_at(x + step_x(d), y + step_y(d));
        if (c == 0) begin
          exp_act[exp_n++] = 1;
          x += step_x(d);
          y += step_y(d);
          break;
        end else if (c == 3) begin
          exp_act[exp_n++] = 4;
          fin = 1;
          break;
        end else begin
          exp_act[exp_n++] = 2;
          d = (d + 1) % 4;
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; act_rdy = 1'b0; sns_vld = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_reset_state();
    do_reset();
    check(act_vld == 1'b1 && act_code == 3'd0, "R1 reset offers turn left", act_code, 0);
    check(done == 1'b0 && sns_rdy == 1'b0, "R1 reset done/sns_rdy low", {done, sns_rdy}, 0);
  endtask

  task automatic run_maze(input string tag, input int sx, input int sy, input int sd, input bit stall_en);
    int x = sx;
    int y = sy;
    int d = sd;
    int idx = 0;
    int stall = 0;
    int cyc = 0;
    bit seen = 0;
    bit after_turn = 0;
    logic [2:0] held = 3'd0;
    build_ref(sx, sy, sd);
    do_reset();
    while (!done && cyc < 3000) begin
      cyc++;
      if (after_turn) begin
        check(sns_rdy && !act_vld, {tag, " R3 sample requested after turn"}, {act_vld, sns_rdy}, 1);
        after_turn = 0;
      end
      if (act_vld && sns_rdy) check(0, {tag, " R8 both channels active"}, 3, 1);
      act_rdy = 1'b0;
      sns_vld = 1'b0;
      if (act_vld) begin
        if (!seen) begin
          check(idx < exp_n && act_code == 3'(exp_act[idx]),
                {tag, " R2 R4 R6 action sequence"}, act_code, exp_act[idx]);
          held = act_code;
          seen = 1;
          stall = (stall_en && (idx % 3 == 1)) ? 2 : 0;
        end else begin
          check(act_code == held, {tag, " R7 held during stall"}, act_code, held);
        end
        if (stall > 0) begin
          stall--;
          sns_vld = 1'b1;  // door code must be ignored here
          sns_code = 2'd3;
        end else begin
          act_rdy = 1'b1;
          case (act_code)
            3'd0: d = (d + 3) % 4;
            3'd2: d = (d + 1) % 4;
            3'd1: begin x += step_x(d); y += step_y(d); end
            default: ;
          endcase
          after_turn = (act_code == 3'd0 || act_code == 3'd2);
          idx++;
          seen = 0;
        end
      end else if (sns_rdy) begin
        sns_vld = 1'b1;
        sns_code = 2'(cell_at(x + step_x(d), y + step_y(d)));
      end
      @(negedge clk);
    end
    act_rdy = 1'b0;
    sns_vld = 1'b0;
    check(done && idx == exp_n, {tag, " R5 run ends after interact"}, idx, exp_n);
    for (int k = 0; k < 4; k++) begin
      act_rdy = 1'b1;
      sns_vld = 1'b1;
      @(negedge clk);
      check(done && !act_vld && !sns_rdy, {tag, " R10 done sticky and quiet"},
            {done, act_vld, sns_rdy}, 4);
    end
    act_rdy = 1'b0;
    sns_vld = 1'b0;
    do_reset();
    check(!done && act_vld && act_code == 3'd0, {tag, " R10 reset clears done"}, done, 0);
  endtask

  task automatic test_mid_reset();
    do_reset();
    act_rdy = 1'b1;
    @(negedge clk);
    act_rdy = 1'b0;
    sns_vld = 1'b1;
    sns_code = 2'd1;
    @(negedge clk);
    sns_vld = 1'b0;
    check(act_vld && act_code == 3'd2, "R6 wall code gives turn right", act_code, 2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(act_vld && act_code == 3'd0 && !sns_rdy, "R9 mid-run reset offers left", act_code, 0);
  endtask

  initial begin
    test_reset_state();
    load_maze("#x###", "#..D#", "#####", "#####");
    run_maze("mazeA", 1, 1, 1, 1'b1);
    load_maze("#####", "#..D#", "#.###", "#####");
    run_maze("mazeB", 1, 2, 2, 1'b0);
    run_maze("mazeB-stall", 1, 2, 2, 1'b1);
    test_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule